// File: doc/BRIEF.md
# Byte-Frame Serial Transmitter

This block turns one byte into an asynchronous serial frame on a single output line. The frame has a low start bit, eight data bits sent least significant bit first, and a high stop bit. The whole frame is placed into a ten-bit register in a single load. The low end of that register drives the line directly. A self-restarting bit timer paces the shifts. Each shift brings in a one at the top, so the line settles high once the stop bit has gone out.

The user places a byte on the data input and raises the start strobe for one clock. The busy output stays high for the ten bit times of the frame. A strobe that arrives while busy is high is dropped. The number of clocks per bit is the parameter `CLKS_PER_BIT`: for example, a 10 MHz clock at 115200 baud needs about 87.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, the serial line is 1 and busy is 0.
- R2: While no frame is in progress, the serial line stays at 1.
- R3: A start strobe sampled while busy is 0 makes the line 0 (the start bit) and busy 1 at the next clock edge.
- R4: Each frame bit holds the line for exactly `CLKS_PER_BIT` clocks. The bit timer gives one single-cycle pulse per bit time and restarts by itself. The line changes only on a timer pulse or a load.
- R5: The line carries, in order: 0 (start), data bit 0 through data bit 7, then 1 (stop).
- R6: After the stop bit the line stays at 1 until the next accepted start.
- R7: Busy stays high for exactly 10 × `CLKS_PER_BIT` clocks per frame. It falls at the clock edge where the stop bit ends.
- R8: A start strobe that arrives while busy is 1 is ignored. The frame in progress keeps its bits and timing, and no second frame follows.
- R9: A start strobe in the first cycle after busy falls is accepted. The load restarts the bit timer whatever its phase, so bit boundaries are aligned to the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to send `data_i` |
| data_i | input | 8 | Byte to send, sampled with an accepted request |
| tx_o | output | 1 | Serial line, idles high |
| busy_o | output | 1 | High while a frame is being sent |

## Verification
On every cycle, the assertions check these relations:
- the line is high whenever busy is low;
- an accepted request puts a low line and a high busy in the next cycle;
- the timer pulse lasts a single cycle;
- the line moves only after a timer pulse or a load;
- busy falls only on a timer pulse.

The order of the bits, their exact widths in clocks, the total busy length, the dropping of requests made mid-frame and back-to-back frames depend on the byte value and on the history of the frame. Only the bench shows these. It runs a behavioural queue model and compares against it every clock, and it adds targeted scenarios.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int DATA_W  = 8;
    localparam int FRAME_W = DATA_W + 2;
    localparam int SCNT_W  = $clog2(FRAME_W + 1);

    // Packed so that the start bit sits at bit 0 and leaves first.
    typedef struct packed {
        logic              stop_bit;
        logic [DATA_W-1:0] payload;
        logic              start_bit;
    } frame_t;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;

    function automatic frame_t make_frame(input logic [DATA_W-1:0] byte_in);
        frame_t f;
        f.stop_bit  = 1'b1;
        f.payload   = byte_in;
        f.start_bit = 1'b0;
        return f;
    endfunction

endpackage

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
    parameter int PERIOD = 87
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic restart_i,
    output logic tick_o
);
    localparam int CW = $clog2(PERIOD + 1);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || restart_i) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = (cnt_q == LAST);

endmodule

// File: rtl/tx_frame_shreg.sv
module tx_frame_shreg
    import uart_tx_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  logic   load_i,
    input  logic   shift_i,
    input  frame_t frame_i,
    output logic   serial_o
);
    logic [FRAME_W-1:0] sr_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sr_q <= '1;
        end else if (load_i) begin
            sr_q <= frame_i;
        end else if (shift_i) begin
            sr_q <= {1'b1, sr_q[FRAME_W-1:1]};
        end
    end

    assign serial_o = sr_q[0];

endmodule

// File: rtl/tx_ctrl.sv
module tx_ctrl
    import uart_tx_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_i,
    input  logic tick_i,
    output logic load_o,
    output logic shift_o,
    output logic busy_o
);
    localparam logic [SCNT_W-1:0] LAST_SHIFT = SCNT_W'(FRAME_W - 1);

    tx_state_e         state_q;
    logic [SCNT_W-1:0] shifts_q;

    assign load_o  = start_i && (state_q == TX_IDLE);
    assign shift_o = tick_i && !load_o;
    assign busy_o  = (state_q == TX_SEND);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q  <= TX_IDLE;
            shifts_q <= '0;
        end else if (load_o) begin
            state_q  <= TX_SEND;
            shifts_q <= '0;
        end else if (shift_o && state_q == TX_SEND) begin
            if (shifts_q == LAST_SHIFT) begin
                state_q  <= TX_IDLE;
                shifts_q <= '0;
            end else begin
                shifts_q <= shifts_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uart_tx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 87
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              start_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              tx_o,
    output logic              busy_o
);
    logic   tick_w;
    logic   load_w;
    logic   shift_w;
    frame_t frame_w;

    assign frame_w = make_frame(data_i);

    tx_bit_timer #(.PERIOD(CLKS_PER_BIT)) timer_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .restart_i (load_w),
        .tick_o    (tick_w)
    );

    tx_ctrl ctrl_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .start_i (start_i),
        .tick_i  (tick_w),
        .load_o  (load_w),
        .shift_o (shift_w),
        .busy_o  (busy_o)
    );

    tx_frame_shreg shreg_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .load_i   (load_w),
        .shift_i  (shift_w),
        .frame_i  (frame_w),
        .serial_o (tx_o)
    );

endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk #(
    parameter int CLKS_PER_BIT = 87
) (
    input logic clk_i,
    input logic rst_i,
    input logic start_i,
    input logic busy_o,
    input logic tx_o,
    input logic tick_w,
    input logic load_w
);
    // R2, R6: the line is high outside a frame
    a_r2_idle_high: assert property (@(posedge clk_i) disable iff (rst_i)
        !busy_o |-> tx_o);

    // R3: an accepted request shows a start bit and busy one edge later
    a_r3_accept: assert property (@(posedge clk_i) disable iff (rst_i)
        (start_i && !busy_o) |=> (!tx_o && busy_o));

    // R4: the timer pulse lasts one cycle
    a_r4_tick_single: assert property (@(posedge clk_i) disable iff (rst_i)
        (CLKS_PER_BIT > 1 && tick_w) |=> !tick_w);

    // R4, R8: the line moves only after a timer pulse or a load
    a_r4_line_steady: assert property (@(posedge clk_i) disable iff (rst_i)
        (!tick_w && !load_w) |=> $stable(tx_o));

    // R7: busy ends only on a bit boundary
    a_r7_busy_drop: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(busy_o) |-> $past(tick_w));

endmodule

bind uart_frame_tx uart_frame_tx_chk #(.CLKS_PER_BIT(CLKS_PER_BIT)) chk_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .start_i (start_i),
    .busy_o  (busy_o),
    .tx_o    (tx_o),
    .tick_w  (tick_w),
    .load_w  (load_w)
);

// File: tb/uart_frame_tx_tb_top.sv
module uart_frame_tx_tb_top;
    localparam int N = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] data = 8'h00;
    logic       tx_o;
    logic       busy_o;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    uart_frame_tx #(.CLKS_PER_BIT(N)) dut_i (
        .clk_i   (clk),
        .rst_i   (rst),
        .start_i (start),
        .data_i  (data),
        .tx_o    (tx_o),
        .busy_o  (busy_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: a queue of bits still to go plus a phase count.
    bit m_q[$];
    int m_tick = 0;
    bit m_line = 1'b1;
    bit m_busy = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            m_q.delete();
            m_tick = 0;
            m_line = 1'b1;
            m_busy = 1'b0;
        end else if (start && !m_busy) begin
            m_q.delete();
            for (int i = 0; i < 8; i++) m_q.push_back(data[i]);
            m_q.push_back(1'b1);
            m_line = 1'b0;
            m_busy = 1'b1;
            m_tick = 0;
        end else if (m_tick == N - 1) begin
            m_tick = 0;
            if (m_q.size() > 0) begin
                m_line = m_q.pop_front();
            end else begin
                m_line = 1'b1;
                m_busy = 1'b0;
            end
        end else begin
            m_tick++;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(tx_o == m_line, "R4 R5 model line", int'(tx_o), int'(m_line));
            chk(busy_o == m_busy, "R7 model busy", int'(busy_o), int'(m_busy));
        end
    end

    task automatic send(input logic [7:0] d, input bit poke, input string req);
        logic [9:0] got;
        logic [9:0] exp;
        int busy_n;
        logic prev;
        got = '0;
        exp = {1'b1, d, 1'b0};
        @(negedge clk);
        start = 1'b1;
        data  = d;
        @(negedge clk);
        start = 1'b0;
        chk(tx_o == 1'b0, {req, " R3 start bit"}, int'(tx_o), 0);
        chk(busy_o == 1'b1, {req, " R3 busy"}, int'(busy_o), 1);
        prev   = tx_o;
        busy_n = 0;
        for (int c = 0; c < 10 * N; c++) begin
            if (c > 0) @(negedge clk);
            if (busy_o) busy_n++;
            if (c % N == N / 2) got[c / N] = tx_o;
            if (c > 0 && c % N != 0)
                chk(tx_o == prev, {req, " R4 mid-bit change"}, int'(tx_o), int'(prev));
            prev = tx_o;
            if (poke && c == 3 * N + 2) begin
                start = 1'b1;
                data  = ~d;
            end
            if (poke && c == 3 * N + 3) start = 1'b0;
        end
        chk(got == exp, {req, poke ? " R8 frame bits" : " R5 frame bits"}, int'(got), int'(exp));
        chk(busy_n == 10 * N, {req, " R7 busy length"}, busy_n, 10 * N);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(tx_o == 1'b1, "R1 reset line", int'(tx_o), 1);
        chk(busy_o == 1'b0, "R1 reset busy", int'(busy_o), 0);
        rst = 1'b0;
        for (int i = 0; i < 3 * N; i++) begin
            @(negedge clk);
            chk(tx_o == 1'b1, "R2 idle line", int'(tx_o), 1);
        end
        send(8'hA5, 1'b0, "A5");
        send(8'h3C, 1'b0, "R9 back-to-back 3C");
        for (int i = 0; i < 2 * N; i++) begin
            @(negedge clk);
            chk(tx_o == 1'b1, "R6 line after stop", int'(tx_o), 1);
            chk(busy_o == 1'b0, "R6 busy after stop", int'(busy_o), 0);
        end
        repeat (3) @(negedge clk);
        send(8'h81, 1'b1, "R8 poke 81");
        for (int i = 0; i < 2 * N; i++) begin
            @(negedge clk);
            chk(busy_o == 1'b0, "R8 no second frame", int'(busy_o), 0);
        end
        repeat (N / 2 + 1) @(negedge clk);
        send(8'h00, 1'b0, "R9 odd phase 00");
        send(8'hFF, 1'b0, "FF");
        repeat (2 * N) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog R7 actual=%0d expected=%0d", cycles, 200000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule